// File: doc/BRIEF.md
# Receive Buffer Status Writer

This block follows one receive buffer at a time while stream data lands in memory under a scatter-gather descriptor. A fetched descriptor supplies a buffer length and the status word it was fetched with. The block then accepts stream beats, each carrying a byte count and a packet-end marker, and adds up the bytes that belong to the current buffer.

When the buffer closes, the block assembles a 32-bit completion word. The word holds the stored byte count, the flags that mark the first and last buffer of a packet, three error flags and a done flag. It presents the word to a write-back port and holds it until that port takes it. Descriptors that were already consumed or that describe an empty buffer are rejected. Errors reported by the data mover, and a beat that would overfill the buffer, stop the engine in a controlled way: the run flag drops at once, and the halted flag rises only after the outstanding write-back has been acknowledged.

Top module: `s2mm_status_writer`

## Requirements
- R1: The completion word places the byte count in bits 25:0, the packet-end flag in bit 26, the packet-start flag in bit 27, the internal error in bit 28, the slave error in bit 29, the decode error in bit 30 and the done flag in bit 31. Count bits at and above LEN_W read as zero. For example, 50 bytes ending a packet in a 1024-byte buffer give a count of 0x32.
- R2: A buffer closes when a beat with the packet-end marker is accepted, or when the count reaches the buffer length. A clean close writes the done flag as 1 and the packet-end flag equal to the marker.
- R3: The packet-start flag is 1 for the first buffer after reset or restart, and for the buffer that follows one closed by the packet-end marker. A buffer in the middle of a packet carries neither flag.
- R4: A descriptor with a buffer length of zero produces a write-back word with only the internal error bit set (0x10000000), and then a halt.
- R5: A descriptor whose fetched status has bit 31 set is stale. It raises sg_err, clears run_stop and sets halted on the next cycle, and it produces no write-back.
- R6: A slave or decode error pulse while a buffer is open closes the buffer. The write-back carries that error bit, the bytes stored so far, the packet-start flag and done = 0, and a halt follows. No beat is accepted in the cycle of the pulse.
- R7: A beat that would take the count past the buffer length is an overrun. The write-back has the count equal to the buffer length, the internal error bit set and done = 0, and a halt follows.
- R8: When an error is detected, run_stop falls at the same clock edge. halted stays low while the error write-back is pending and rises on the cycle after it is acknowledged.
- R9: s_ready is low while no descriptor is loaded, while a write-back is pending and while halted. desc_ready is high only when the engine is running and idle.
- R10: wb_valid, once raised, stays high with an unchanged wb_status until wb_ready is sampled high.
- R11: A run_req pulse while halted sets run_stop, clears halted and sg_err, and restarts packet-start tracking. A run_req pulse while running has no effect.
- R12: Slave or decode error pulses while no buffer is open are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_req | input | 1 | Pulse requesting a restart after a halt |
| run_stop | output | 1 | Engine run flag |
| halted | output | 1 | Engine fully stopped |
| sg_err | output | 1 | Stale descriptor seen |
| desc_valid | input | 1 | Fetched descriptor available |
| desc_ready | output | 1 | Descriptor accepted this cycle when valid |
| desc_len | input | LEN_W | Buffer length in bytes |
| desc_status | input | 32 | Status word as fetched |
| s_valid | input | 1 | Stream beat valid |
| s_ready | output | 1 | Stream beat accepted |
| s_bytes | input | clog2(BEAT_BYTES+1) | Bytes carried by the beat |
| s_last | input | 1 | Beat ends the packet |
| mover_slv_err | input | 1 | Slave error pulse from the data mover |
| mover_dec_err | input | 1 | Decode error pulse from the data mover |
| wb_valid | output | 1 | Completion word ready for write-back |
| wb_ready | input | 1 | Write-back accepted |
| wb_status | output | 32 | Completion word |

## Verification
On every cycle the assertions check the halt handshake: stream and descriptor ready stay low while halted, halted follows one cycle after an acknowledged error write-back, and a word carrying an error is never marked done and never appears while the run flag is set. They also check that the write-back word stays stable under back-pressure and that count bits above the configured width stay zero. Only the bench's scenarios can show the counted values themselves. These are the byte totals for buffers that fill or end early, the way packet-start and packet-end flags follow packets spread over random buffer sizes, the exact error word for each fault, and that pulses and requests which should be ignored leave later buffers unchanged.

// File: rtl/s2mm_status_writer.sv
module s2mm_status_writer #(
  parameter int LEN_W      = 26,
  parameter int BEAT_BYTES = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              run_req,
  output logic                              run_stop,
  output logic                              halted,
  output logic                              sg_err,
  input  logic                              desc_valid,
  output logic                              desc_ready,
  input  logic [LEN_W-1:0]                  desc_len,
  input  logic [31:0]                       desc_status,
  input  logic                              s_valid,
  output logic                              s_ready,
  input  logic [$clog2(BEAT_BYTES+1)-1:0]   s_bytes,
  input  logic                              s_last,
  input  logic                              mover_slv_err,
  input  logic                              mover_dec_err,
  output logic                              wb_valid,
  input  logic                              wb_ready,
  output logic [31:0]                       wb_status
);
  localparam int NB_W = $clog2(BEAT_BYTES + 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_WB, S_HALT} st_t;

  st_t             st;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [31:0]     word_q;
  logic            run_q, sg_q, sof_next;
  logic [LEN_W:0]  sum;
  logic            mover_err, over, full;

  function automatic logic [31:0] pack(input logic [LEN_W-1:0] cnt, input logic eof,
                                       input logic sof, input logic ie, input logic se,
                                       input logic de, input logic done);
    logic [31:0] w;
    w = '0;
    w[LEN_W-1:0] = cnt;
    w[26] = eof;
    w[27] = sof;
    w[28] = ie;
    w[29] = se;
    w[30] = de;
    w[31] = done;
    return w;
  endfunction

  assign mover_err  = mover_slv_err | mover_dec_err;
  assign sum        = {1'b0, cnt_q} + (LEN_W+1)'(s_bytes);
  assign over       = sum > {1'b0, len_q};
  assign full       = sum == {1'b0, len_q};

  assign desc_ready = run_q && (st == S_IDLE);
  assign s_ready    = (st == S_FILL) && !mover_err;
  assign wb_valid   = (st == S_WB);
  assign wb_status  = word_q;
  assign halted     = (st == S_HALT);
  assign run_stop   = run_q;
  assign sg_err     = sg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      run_q    <= 1'b1;
      sg_q     <= 1'b0;
      sof_next <= 1'b1;
      len_q    <= '0;
      cnt_q    <= '0;
      word_q   <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (desc_valid && desc_ready) begin
            if (desc_status[31]) begin
              sg_q  <= 1'b1;
              run_q <= 1'b0;
              st    <= S_HALT;
            end else if (desc_len == '0) begin
              word_q <= pack('0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
              run_q  <= 1'b0;
              st     <= S_WB;
            end else begin
              len_q <= desc_len;
              cnt_q <= '0;
              st    <= S_FILL;
            end
          end
        end
        S_FILL: begin
          if (mover_err) begin
            word_q <= pack(cnt_q, 1'b0, sof_next, 1'b0, mover_slv_err, mover_dec_err, 1'b0);
            run_q  <= 1'b0;
            st     <= S_WB;
          end else if (s_valid) begin
            if (over) begin
              word_q <= pack(len_q, s_last, sof_next, 1'b1, 1'b0, 1'b0, 1'b0);
              run_q  <= 1'b0;
              st     <= S_WB;
            end else if (s_last || full) begin
              word_q   <= pack(sum[LEN_W-1:0], s_last, sof_next, 1'b0, 1'b0, 1'b0, 1'b1);
              sof_next <= s_last;
              st       <= S_WB;
            end else begin
              cnt_q <= sum[LEN_W-1:0];
            end
          end
        end
        S_WB: begin
          if (wb_ready) st <= run_q ? S_IDLE : S_HALT;
        end
        default: begin
          if (run_req) begin
            run_q    <= 1'b1;
            sg_q     <= 1'b0;
            sof_next <= 1'b1;
            st       <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

module s2mm_status_writer_chk #(
  parameter int LEN_W = 26
) (
  input logic        clk,
  input logic        rst_n,
  input logic        run_req,
  input logic        run_stop,
  input logic        halted,
  input logic        sg_err,
  input logic        desc_ready,
  input logic        s_ready,
  input logic        wb_valid,
  input logic        wb_ready,
  input logic [31:0] wb_status
);
  // R9
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!s_ready && !desc_ready));

  // R10
  wb_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_status)));

  // R8
  halt_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && wb_ready && !run_stop) |=> halted);

  // R8
  no_early_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !run_stop) |-> !halted);

  // R6
  err_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> !(wb_status[31] && (|wb_status[30:28])));

  // R6
  err_stops_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && (|wb_status[30:28])) |-> !run_stop);

  // R5
  stale_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sg_err) |-> (halted && !run_stop));

  // R11
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && run_req) |=> (run_stop && !halted && !sg_err));

  generate
    if (LEN_W < 26) begin : g_upper
      // R1
      upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_status[25:LEN_W] == '0));
    end
  endgenerate
endmodule

bind s2mm_status_writer s2mm_status_writer_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_req(run_req), .run_stop(run_stop),
  .halted(halted), .sg_err(sg_err), .desc_ready(desc_ready), .s_ready(s_ready),
  .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_status(wb_status)
);

// File: tb/s2mm_status_writer_tb.sv
`timescale 1ns/1ps
module s2mm_status_writer_tb;
  localparam int LEN_W = 16;
  localparam int BB    = 4;
  localparam int NB_W  = $clog2(BB + 1);

  logic clk = 0, rst_n = 0, run_req = 0;
  logic run_stop, halted, sg_err, desc_ready, s_ready, wb_valid;
  logic desc_valid = 0;
  logic [LEN_W-1:0] desc_len = '0;
  logic [31:0] desc_status = '0;
  logic s_valid = 0, s_last = 0, slv = 0, dec = 0, wb_ready = 0;
  logic [NB_W-1:0] s_bytes = '0;
  logic [31:0] wb_status;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  s2mm_status_writer #(.LEN_W(LEN_W), .BEAT_BYTES(BB)) u_dut (
    .clk(clk), .rst_n(rst_n), .run_req(run_req), .run_stop(run_stop),
    .halted(halted), .sg_err(sg_err), .desc_valid(desc_valid),
    .desc_ready(desc_ready), .desc_len(desc_len), .desc_status(desc_status),
    .s_valid(s_valid), .s_ready(s_ready), .s_bytes(s_bytes), .s_last(s_last),
    .mover_slv_err(slv), .mover_dec_err(dec), .wb_valid(wb_valid),
    .wb_ready(wb_ready), .wb_status(wb_status)
  );

  function automatic logic [31:0] word(input int cnt, input bit eof, input bit sof,
                                       input bit ie, input bit se, input bit de, input bit done);
    logic [25:0] c;
    c = 26'(cnt);
    return {done, de, se, ie, sof, eof, c};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_desc(input int len, input logic [31:0] st);
    desc_valid = 1; desc_len = LEN_W'(len); desc_status = st;
    #1;
    while (!desc_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    desc_valid = 0;
  endtask

  task automatic beat(input int nb, input bit last);
    s_valid = 1; s_bytes = NB_W'(nb); s_last = last;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    s_valid = 0; s_last = 0;
  endtask

  task automatic collect(input logic [31:0] exp, input string req);
    int guard = 0;
    int d;
    while (!wb_valid && guard < 100) begin @(negedge clk); guard++; end
    chk(wb_valid, "R10 write-back raised", 32'(wb_valid), 32'd1);
    chk(!s_ready, "R9 ready low during write-back", 32'(s_ready), 32'd0);
    chk(wb_status == exp, req, wb_status, exp);
    d = $urandom % 4;
    for (int i = 0; i < d; i++) begin
      @(negedge clk);
      chk(wb_valid && wb_status == exp, "R10 held under back-pressure", wb_status, exp);
      if (!run_stop) chk(!halted, "R8 not halted before ack", 32'(halted), 32'd0);
    end
    wb_ready = 1;
    @(posedge clk); @(negedge clk);
    wb_ready = 0;
  endtask

  task automatic restart();
    run_req = 1;
    @(negedge clk);
    run_req = 0;
    chk(run_stop && !halted && !sg_err, "R11 restart", {29'd0, run_stop, halted, sg_err}, 32'h4);
  endtask

  task automatic halt_check(input string req);
    chk(halted && !run_stop, req, {30'd0, halted, run_stop}, 32'h2);
    chk(!s_ready && !desc_ready, "R9 halted quiet", {30'd0, s_ready, desc_ready}, 32'h0);
  endtask

  initial begin
    #600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int pkt, blen, cnt, nb, gap;
    bit last, sof;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(run_stop && !halted && !sg_err && !wb_valid, "R8 reset state",
        {28'd0, run_stop, halted, sg_err, wb_valid}, 32'h8);
    chk(desc_ready && !s_ready, "R9 ready after reset", {30'd0, desc_ready, s_ready}, 32'h2);

    // R2 R3: random packets across random buffers
    sof = 1;
    for (int p = 0; p < 30; p++) begin
      pkt = 1 + $urandom % 40;
      while (pkt > 0) begin
        blen = 1 + $urandom % 16;
        send_desc(blen, 32'h0);
        cnt = 0; last = 0;
        while (!last && cnt < blen) begin
          nb = 1 + $urandom % BB;
          if (nb > pkt) nb = pkt;
          if (nb > blen - cnt) nb = blen - cnt;
          last = (nb == pkt);
          gap = $urandom % 3;
          repeat (gap) @(negedge clk);
          beat(nb, last);
          cnt += nb; pkt -= nb;
        end
        collect(word(cnt, last, sof, 0, 0, 0, 1), "R2 R3 random buffer word");
        sof = last;
      end
    end

    // R1: 50 bytes into a 1024-byte buffer
    send_desc(1024, 32'h0);
    for (int i = 0; i < 12; i++) beat(4, 0);
    beat(2, 1);
    collect(32'h8C000032, "R1 short packet count");

    // R3 R11: middle buffer, run_req while running ignored
    send_desc(8, 32'h0);
    beat(4, 0); beat(4, 0);
    collect(word(8, 0, 1, 0, 0, 0, 1), "R2 R3 buffer filled");
    run_req = 1; @(negedge clk); run_req = 0;
    chk(run_stop && !halted, "R11 run_req while running", {30'd0, run_stop, halted}, 32'h2);
    send_desc(8, 32'h0);
    beat(2, 1);
    collect(word(2, 1, 0, 0, 0, 0, 1), "R3 R11 continuation buffer");

    // R12: error pulses while idle
    dec = 1; slv = 1; @(negedge clk); dec = 0; slv = 0;
    @(negedge clk);
    chk(run_stop && !halted && desc_ready, "R12 idle error ignored",
        {29'd0, run_stop, halted, desc_ready}, 32'h5);
    send_desc(4, 32'h0);
    beat(4, 1);
    collect(word(4, 1, 1, 0, 0, 0, 1), "R12 clean buffer after ignored pulse");

    // R6 R8: slave error mid-buffer
    send_desc(16, 32'h0);
    beat(4, 0); beat(4, 0);
    s_valid = 1; s_bytes = 4; slv = 1;
    #1;
    chk(!s_ready, "R6 no beat during error", 32'(s_ready), 32'd0);
    @(negedge clk);
    slv = 0; s_valid = 0;
    chk(!run_stop && !halted, "R8 run cleared, not yet halted", {30'd0, run_stop, halted}, 32'h0);
    collect(word(8, 0, 1, 0, 1, 0, 0), "R6 slave error word");
    halt_check("R8 halted after ack");
    restart();

    // R6: decode error on first beat position
    send_desc(12, 32'h0);
    beat(3, 0);
    dec = 1; @(negedge clk); dec = 0;
    collect(word(3, 0, 1, 0, 0, 1, 0), "R6 decode error word");
    halt_check("R8 halted after decode error");
    restart();

    // R4: zero length
    send_desc(0, 32'h0);
    chk(!run_stop && !halted, "R4 R8 zero length stops run", {30'd0, run_stop, halted}, 32'h0);
    collect(32'h10000000, "R4 zero length word");
    halt_check("R4 halted");
    restart();

    // R5: stale descriptor
    send_desc(4, 32'h80000000);
    chk(sg_err && !wb_valid, "R5 stale flagged, no write-back", {30'd0, sg_err, wb_valid}, 32'h2);
    halt_check("R5 halted");
    restart();

    // R7: overrun
    send_desc(5, 32'h0);
    beat(4, 0); beat(4, 0);
    collect(word(5, 0, 1, 1, 0, 0, 0), "R7 overrun word");
    halt_check("R7 halted");
    restart();

    // R3: start flag after restart
    send_desc(6, 32'h0);
    beat(3, 0); beat(3, 1);
    collect(word(6, 1, 1, 0, 0, 0, 1), "R3 R11 start after restart");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule